// File: doc/BRIEF.md
# Display Interrupt Status and Mask Unit

This block gathers the interrupt-worthy events of a multi-channel display controller into two status registers and turns them into one level-sensitive interrupt line. Events arrive as single-cycle strobes carrying a kind, a channel number and that channel's frame ID. Events on channel 0 land in a base status register. Events on the other channels land in a per-channel status register that has one byte-wide group per event kind.

Software clears status bits by writing ones. It can mask each source through two mask registers, and it reads back the frame ID of the channel that raised the most recent event. If an event that counts toward the interrupt arrives while the line is already high, or if a bus error arrives at that time, the event does not overwrite the ID register. Instead it sets a sticky "another interrupt pending" flag. The block also holds the controller's enable and disable-at-end-of-frame bits, because two status flags come from those bits.

Register addresses are word indices. 0 is control: bit 0 is enable, bit 1 is disable-at-end-of-frame. 1 is the base mask, 2 is the channel mask, 3 is the base status, 4 is the channel status and 5 is the frame ID.

Top module: `lcd_irq_unit`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq` is low.
- R2: Start of frame, end of frame, branch and underrun events go to base status bits 1, 8, 9 and 4 when they are on channel 0. On channel n (1 to 6) they go to channel status bits n-1, n+7, n+15 and n+23. The event kind codes are 0 start of frame, 1 end of frame, 2 branch and 3 underrun.
- R3: A start-of-frame event is recorded only when `ev_sof_en` is high. An end-of-frame event is recorded only when `ev_eof_en` is high. An event that is not recorded leaves status and the ID register unchanged.
- R4: Kind 4 is a bus error. It sets base bit 2 and writes the channel to bits 30:28. Kind 5 sets bit 6 (output underrun), kind 6 sets bit 11 (read status) and kind 7 sets bit 12 (command done).
- R5: `irq` is the OR of base status bits 0, 1, 4 to 9, 11 and 12 whose base mask bit is clear, and of the channel status bits (layout 0x3F3F3F3F) whose channel mask bit is clear. It is registered, so it follows status one cycle later. Mask writes keep only those bit positions.
- R6: A recorded event on an unmasked source, or any bus error, that arrives while `irq` is high sets base bit 10 and leaves the ID register unchanged. A recorded channel event in any other situation, or a bus error while `irq` is low, loads the event's frame ID. Kinds 5 to 7 never load it.
- R7: A write to base status clears the bits among 11:0 that are written as 1. When bit 2 is written as 1, bits 30:28 are cleared as well. Bit 12 cannot be cleared this way.
- R8: A write to channel status clears only the written-1 bits inside 0x003E3F3F. The underrun bits and the channel-1 branch bit stay set.
- R9: A control write that takes enable from 1 to 0 sets base bit 7.
- R10: A `frame_end` pulse while both enable and disable-at-end-of-frame are set clears enable and sets base bit 0. Otherwise the pulse has no effect.
- R11: When an event sets a status bit in the same cycle as a write that clears that bit, the bit ends up set.
- R12: `reg_rdata` presents the addressed register one cycle after `reg_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 3 | Event kind code |
| ev_chan | input | CH_W | Channel of the event |
| ev_fid | input | FID_W | Frame ID of that channel |
| ev_sof_en | input | 1 | Channel command enables start-of-frame reporting |
| ev_eof_en | input | 1 | Channel command enables end-of-frame reporting |
| frame_end | input | 1 | Pulse at the end of each frame |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume the following about the inputs: the channel number is below the channel count, reads and writes never share a cycle, and reset is held for at least two clocks before it is released. The bench drives one strobe or register access per cycle, at the falling clock edge, and it only uses channels 0 to 6. It puts a full reset between the table rows, so each row starts with the interrupt line low. The directed tests then build the interrupt-already-high situations on purpose.

// File: rtl/lcdirq_pkg.sv
package lcdirq_pkg;
  typedef enum logic [2:0] {
    EV_SOF      = 3'd0,
    EV_EOF      = 3'd1,
    EV_BRANCH   = 3'd2,
    EV_UNDERRUN = 3'd3,
    EV_BUSERR   = 3'd4,
    EV_OUTUNDER = 3'd5,
    EV_RDSTAT   = 3'd6,
    EV_CMD      = 3'd7
  } ev_kind_e;

  localparam int REG_W = 32;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_MASK0 = 3'd1;
  localparam logic [2:0] A_MASK1 = 3'd2;
  localparam logic [2:0] A_STAT0 = 3'd3;
  localparam logic [2:0] A_STAT1 = 3'd4;
  localparam logic [2:0] A_FID   = 3'd5;

  // base status bit positions
  localparam int S0_LDD  = 0;
  localparam int S0_SOF  = 1;
  localparam int S0_BER  = 2;
  localparam int S0_UND  = 4;
  localparam int S0_OUT  = 6;
  localparam int S0_QD   = 7;
  localparam int S0_EOF  = 8;
  localparam int S0_BS   = 9;
  localparam int S0_SINT = 10;
  localparam int S0_RDST = 11;
  localparam int S0_CMD  = 12;
  localparam int S0_BCH_LO = 28;

  localparam logic [REG_W-1:0] S0_MASKABLE = 32'h0000_1BF3;
  localparam logic [REG_W-1:0] S0_W1C      = 32'h0000_0FFF;
  localparam logic [REG_W-1:0] S1_LAYOUT   = 32'h3F3F_3F3F;
  localparam logic [REG_W-1:0] S1_W1C      = 32'h003E_3F3F;

  // channel status groups: bit = group base + channel - 1
  localparam int GRP_SOF = 0;
  localparam int GRP_EOF = 8;
  localparam int GRP_BS  = 16;
  localparam int GRP_UND = 24;
endpackage

// File: rtl/lcdirq_evdec.sv
module lcdirq_evdec
  import lcdirq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int CH_W   = 3
) (
  input  logic             ev_valid,
  input  logic [2:0]       ev_kind,
  input  logic [CH_W-1:0]  ev_chan,
  input  logic             ev_sof_en,
  input  logic             ev_eof_en,
  input  logic [REG_W-1:0] mask0,
  input  logic [REG_W-1:0] mask1,
  input  logic             irq_now,
  output logic [REG_W-1:0] set0,
  output logic [REG_W-1:0] set1,
  output logic             ber_set,
  output logic             sint_set,
  output logic             fid_load
);
  // one-hot among start, end, branch, underrun
  logic [3:0]       grp_hit;
  logic             chan_ev;
  logic             unmasked;
  logic [3:0]       ch_set [NUM_CH];

  always_comb begin
    grp_hit = '0;
    if (ev_valid) begin
      case (ev_kind_e'(ev_kind))
        EV_SOF:      grp_hit[0] = ev_sof_en;
        EV_EOF:      grp_hit[1] = ev_eof_en;
        EV_BRANCH:   grp_hit[2] = 1'b1;
        EV_UNDERRUN: grp_hit[3] = 1'b1;
        default:     grp_hit    = '0;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      if (g == 0) begin : g_base
        assign ch_set[g] = '0;
      end else begin : g_other
        assign ch_set[g] = (ev_chan == CH_W'(g)) ? grp_hit : 4'b0000;
      end
    end
  endgenerate

  always_comb begin
    set1 = '0;
    for (int c = 1; c < NUM_CH; c++) begin
      set1[GRP_SOF + c - 1] = ch_set[c][0];
      set1[GRP_EOF + c - 1] = ch_set[c][1];
      set1[GRP_BS  + c - 1] = ch_set[c][2];
      set1[GRP_UND + c - 1] = ch_set[c][3];
    end
  end

  always_comb begin
    set0 = '0;
    if (ev_chan == '0) begin
      set0[S0_SOF] = grp_hit[0];
      set0[S0_EOF] = grp_hit[1];
      set0[S0_BS]  = grp_hit[2];
      set0[S0_UND] = grp_hit[3];
    end
    if (ev_valid) begin
      case (ev_kind_e'(ev_kind))
        EV_OUTUNDER: set0[S0_OUT]  = 1'b1;
        EV_RDSTAT:   set0[S0_RDST] = 1'b1;
        EV_CMD:      set0[S0_CMD]  = 1'b1;
        default:     ;
      endcase
    end
  end

  assign chan_ev  = |grp_hit;
  assign ber_set  = ev_valid && (ev_kind_e'(ev_kind) == EV_BUSERR);
  assign unmasked = (|(set0 & ~mask0 & S0_MASKABLE)) | (|(set1 & ~mask1 & S1_LAYOUT));
  assign sint_set = irq_now && (ber_set || unmasked);
  assign fid_load = (chan_ev || ber_set) && !sint_set;
endmodule

// File: rtl/lcdirq_level.sv
module lcdirq_level
  import lcdirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] stat0,
  input  logic [REG_W-1:0] stat1,
  input  logic [REG_W-1:0] mask0,
  input  logic [REG_W-1:0] mask1,
  output logic             irq_q
);
  logic level;

  assign level = (|(stat0 & ~mask0 & S0_MASKABLE)) | (|(stat1 & ~mask1 & S1_LAYOUT));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= level;
  end
endmodule

// File: rtl/lcd_irq_unit.sv
module lcd_irq_unit
  import lcdirq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int FID_W  = 32,
  parameter int ADDR_W = 3,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ev_valid,
  input  logic [2:0]        ev_kind,
  input  logic [CH_W-1:0]   ev_chan,
  input  logic [FID_W-1:0]  ev_fid,
  input  logic              ev_sof_en,
  input  logic              ev_eof_en,
  input  logic              frame_end,
  output logic              irq
);
  logic             ctrl_en, ctrl_dis;
  logic [REG_W-1:0] mask0_q, mask1_q, stat0_q, stat1_q;
  logic [REG_W-1:0] stat0_n, stat1_n, clr0, clr1;
  logic [FID_W-1:0] fid_q;
  logic [REG_W-1:0] set0, set1;
  logic             ber_set, sint_set, fid_load;
  logic             wr_ctrl, wr_stat0, wr_stat1, qd_set, ldd_set;

  assign wr_ctrl  = reg_wr_en && (reg_addr == ADDR_W'(A_CTRL));
  assign wr_stat0 = reg_wr_en && (reg_addr == ADDR_W'(A_STAT0));
  assign wr_stat1 = reg_wr_en && (reg_addr == ADDR_W'(A_STAT1));
  assign qd_set   = wr_ctrl && ctrl_en && !reg_wdata[0];
  assign ldd_set  = frame_end && ctrl_en && ctrl_dis;

  lcdirq_evdec #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
    .ev_valid (ev_valid),
    .ev_kind  (ev_kind),
    .ev_chan  (ev_chan),
    .ev_sof_en(ev_sof_en),
    .ev_eof_en(ev_eof_en),
    .mask0    (mask0_q),
    .mask1    (mask1_q),
    .irq_now  (irq),
    .set0     (set0),
    .set1     (set1),
    .ber_set  (ber_set),
    .sint_set (sint_set),
    .fid_load (fid_load)
  );

  lcdirq_level u_lvl (
    .clk  (clk),
    .rst  (rst),
    .stat0(stat0_q),
    .stat1(stat1_q),
    .mask0(mask0_q),
    .mask1(mask1_q),
    .irq_q(irq)
  );

  // clears first, then sets: a same-cycle event wins
  always_comb begin
    clr0 = wr_stat0 ? (reg_wdata & S0_W1C) : '0;
    if (wr_stat0 && reg_wdata[S0_BER]) clr0[S0_BCH_LO +: 3] = 3'b111;
    stat0_n = (stat0_q & ~clr0) | set0;
    if (ber_set) begin
      stat0_n[S0_BER]         = 1'b1;
      stat0_n[S0_BCH_LO +: 3] = 3'(ev_chan);
    end
    if (sint_set) stat0_n[S0_SINT] = 1'b1;
    if (qd_set)   stat0_n[S0_QD]   = 1'b1;
    if (ldd_set)  stat0_n[S0_LDD]  = 1'b1;
    clr1    = wr_stat1 ? (reg_wdata & S1_W1C) : '0;
    stat1_n = (stat1_q & ~clr1) | set1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en   <= 1'b0;
      ctrl_dis  <= 1'b0;
      mask0_q   <= '0;
      mask1_q   <= '0;
      stat0_q   <= '0;
      stat1_q   <= '0;
      fid_q     <= '0;
      reg_rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en  <= reg_wdata[0];
        ctrl_dis <= reg_wdata[1];
      end else if (ldd_set) begin
        ctrl_en  <= 1'b0;
      end
      if (reg_wr_en && reg_addr == ADDR_W'(A_MASK0)) mask0_q <= reg_wdata & S0_MASKABLE;
      if (reg_wr_en && reg_addr == ADDR_W'(A_MASK1)) mask1_q <= reg_wdata & S1_LAYOUT;
      stat0_q <= stat0_n;
      stat1_q <= stat1_n;
      if (fid_load) fid_q <= ev_fid;
      if (reg_rd_en) begin
        case (reg_addr)
          ADDR_W'(A_CTRL):  reg_rdata <= {30'd0, ctrl_dis, ctrl_en};
          ADDR_W'(A_MASK0): reg_rdata <= mask0_q;
          ADDR_W'(A_MASK1): reg_rdata <= mask1_q;
          ADDR_W'(A_STAT0): reg_rdata <= stat0_q;
          ADDR_W'(A_STAT1): reg_rdata <= stat1_q;
          ADDR_W'(A_FID):   reg_rdata <= REG_W'(fid_q);
          default:          reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcdirq_chk.sv
module lcdirq_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              frame_end,
  input logic [31:0]       stat0,
  input logic [31:0]       stat1,
  input logic [31:0]       mask1,
  input logic              ctrl_en,
  input logic              ctrl_dis
);
  // R5
  chan_level_chk: assert property (@(posedge clk) disable iff (rst)
    (|(stat1 & ~mask1 & 32'h3F3F3F3F)) |=> irq);

  // R6
  sint_needs_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat0[10]) |-> $past(irq));

  // R4
  berr_field_chk: assert property (@(posedge clk) disable iff (rst)
    (stat0[30:28] != 3'd0) |-> stat0[2]);

  // R10
  frame_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_end && ctrl_en && ctrl_dis && !(reg_wr_en && reg_addr == '0))
      |=> (!ctrl_en && stat0[0]));

  // R9
  quick_dis_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_addr == '0 && !reg_wdata[0] && ctrl_en) |=> stat0[7]);

  // R8
  sticky_ch_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat1 & 32'h3F010000) & $past(stat1 & 32'h3F010000))
             == $past(stat1 & 32'h3F010000));
endmodule

bind lcd_irq_unit lcdirq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq),
  .reg_wr_en(reg_wr_en),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .frame_end(frame_end),
  .stat0    (stat0_q),
  .stat1    (stat1_q),
  .mask1    (mask1_q),
  .ctrl_en  (ctrl_en),
  .ctrl_dis (ctrl_dis)
);

// File: tb/tb_lcd_irq_unit.sv
`timescale 1ns/1ps
module tb_lcd_irq_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_valid = 1'b0;
  logic [2:0]  ev_kind = '0;
  logic [2:0]  ev_chan = '0;
  logic [31:0] ev_fid = '0;
  logic        ev_sof_en = 1'b0, ev_eof_en = 1'b0;
  logic        frame_end = 1'b0;
  logic        irq;
  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  lcd_irq_unit dut (.*);

  typedef struct packed {
    logic [2:0]  kind;
    logic [2:0]  chan;
    logic [7:0]  fid;
    logic        sof;
    logic        eof;
    logic [31:0] s0;
    logic [31:0] s1;
    logic [7:0]  id;
    logic        irq;
  } vec_t;

  // R2 R3 R4 R5 R6 expectations, one event after reset
  localparam vec_t VEC [15] = '{
    '{3'd0, 3'd0, 8'h11, 1'b1, 1'b0, 32'h0000_0002, 32'h0,         8'h11, 1'b1},
    '{3'd0, 3'd0, 8'h12, 1'b0, 1'b0, 32'h0,         32'h0,         8'h00, 1'b0},
    '{3'd1, 3'd3, 8'h22, 1'b0, 1'b1, 32'h0,         32'h0000_0400, 8'h22, 1'b1},
    '{3'd1, 3'd3, 8'h23, 1'b0, 1'b0, 32'h0,         32'h0,         8'h00, 1'b0},
    '{3'd2, 3'd0, 8'h33, 1'b0, 1'b0, 32'h0000_0200, 32'h0,         8'h33, 1'b1},
    '{3'd2, 3'd6, 8'h44, 1'b0, 1'b0, 32'h0,         32'h0020_0000, 8'h44, 1'b1},
    '{3'd3, 3'd0, 8'h55, 1'b0, 1'b0, 32'h0000_0010, 32'h0,         8'h55, 1'b1},
    '{3'd3, 3'd2, 8'h56, 1'b0, 1'b0, 32'h0,         32'h0200_0000, 8'h56, 1'b1},
    '{3'd4, 3'd5, 8'h66, 1'b0, 1'b0, 32'h5000_0004, 32'h0,         8'h66, 1'b0},
    '{3'd5, 3'd0, 8'h77, 1'b0, 1'b0, 32'h0000_0040, 32'h0,         8'h00, 1'b1},
    '{3'd6, 3'd0, 8'h78, 1'b0, 1'b0, 32'h0000_0800, 32'h0,         8'h00, 1'b1},
    '{3'd7, 3'd0, 8'h79, 1'b0, 1'b0, 32'h0000_1000, 32'h0,         8'h00, 1'b1},
    '{3'd0, 3'd1, 8'h88, 1'b1, 1'b0, 32'h0,         32'h0000_0001, 8'h88, 1'b1},
    '{3'd2, 3'd1, 8'h89, 1'b0, 1'b0, 32'h0,         32'h0001_0000, 8'h89, 1'b1},
    '{3'd1, 3'd6, 8'h8A, 1'b0, 1'b1, 32'h0,         32'h0000_2000, 8'h8A, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd_en = 1'b0; d = reg_rdata;
  endtask

  task automatic ev(input logic [2:0] k, input logic [2:0] c, input logic [31:0] f,
                    input logic s, input logic e);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_chan = c; ev_fid = f; ev_sof_en = s; ev_eof_en = e;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1 reset state, R12 read path
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); check("R1 reset register", v, 32'h0);
    end
    check("R1 reset irq", {31'd0, irq}, 32'h0);

    for (int i = 0; i < 15; i++) begin
      do_reset();
      ev(VEC[i].kind, VEC[i].chan, {24'd0, VEC[i].fid}, VEC[i].sof, VEC[i].eof);
      rd(3'd3, v); check("R2/R3/R4 base status", v, VEC[i].s0);
      rd(3'd4, v); check("R2/R3 channel status", v, VEC[i].s1);
      rd(3'd5, v); check("R6 frame id", v, {24'd0, VEC[i].id});
      check("R5 irq level", {31'd0, irq}, {31'd0, VEC[i].irq});
    end

    // R5 registered timing and masks
    do_reset();
    ev(3'd0, 3'd0, 32'h1, 1'b1, 1'b0);
    check("R5 irq one cycle late", {31'd0, irq}, 32'h0);
    @(negedge clk);
    check("R5 irq after one cycle", {31'd0, irq}, 32'h1);
    do_reset();
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R5 channel mask readback", v, 32'h3F3F_3F3F);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); check("R5 base mask readback", v, 32'h0000_1BF3);
    ev(3'd1, 3'd3, 32'h5, 1'b0, 1'b1);
    rd(3'd4, v); check("R5 masked status kept", v, 32'h0000_0400);
    check("R5 masked irq low", {31'd0, irq}, 32'h0);
    wr(3'd2, 32'h0);
    rd(3'd4, v);
    check("R5 unmasked irq high", {31'd0, irq}, 32'h1);

    // R6 second unmasked event while high
    do_reset();
    ev(3'd0, 3'd0, 32'h11, 1'b1, 1'b0);
    ev(3'd1, 3'd0, 32'h99, 1'b0, 1'b1);
    rd(3'd3, v); check("R6 subsequent flag", v, 32'h0000_0502);
    rd(3'd5, v); check("R6 id kept", v, 32'h11);
    // R6 masked event while high loads id
    do_reset();
    ev(3'd0, 3'd0, 32'h11, 1'b1, 1'b0);
    wr(3'd1, 32'h0000_0200);
    ev(3'd2, 3'd0, 32'h66, 1'b0, 1'b0);
    rd(3'd3, v); check("R6 masked no flag", v, 32'h0000_0202);
    rd(3'd5, v); check("R6 masked loads id", v, 32'h66);
    // R6 bus error while high
    ev(3'd4, 3'd3, 32'h70, 1'b0, 1'b0);
    rd(3'd3, v); check("R6 bus error flag", v, 32'h3000_0606);
    rd(3'd5, v); check("R6 bus error id kept", v, 32'h66);
    // R7 clearing bus error clears channel field
    wr(3'd3, 32'h0000_0004);
    rd(3'd3, v); check("R7 bus error clear", v, 32'h0000_0602);
    wr(3'd3, 32'h0000_0600);
    rd(3'd3, v); check("R7 selective clear", v, 32'h0000_0002);
    do_reset();
    ev(3'd7, 3'd0, 32'h0, 1'b0, 1'b0);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); check("R7 bit 12 not cleared", v, 32'h0000_1000);

    // R8 channel status clear coverage
    do_reset();
    ev(3'd3, 3'd2, 32'h0, 1'b0, 1'b0);
    ev(3'd2, 3'd1, 32'h0, 1'b0, 1'b0);
    ev(3'd0, 3'd1, 32'h0, 1'b1, 1'b0);
    ev(3'd2, 3'd4, 32'h0, 1'b0, 1'b0);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); check("R8 protected bits stay", v, 32'h0201_0000);

    // R9 quick disable
    do_reset();
    wr(3'd0, 32'h1);
    rd(3'd3, v); check("R9 enable alone no flag", v, 32'h0);
    wr(3'd0, 32'h0);
    rd(3'd3, v); check("R9 quick disable flag", v, 32'h0000_0080);
    wr(3'd3, 32'h0000_0080);
    wr(3'd0, 32'h0);
    rd(3'd3, v); check("R9 no flag when already off", v, 32'h0);

    // R10 frame end
    do_reset();
    wr(3'd0, 32'h1);
    pulse_end();
    rd(3'd0, v); check("R10 ignored without disable", v, 32'h1);
    rd(3'd3, v); check("R10 no done flag", v, 32'h0);
    wr(3'd0, 32'h3);
    pulse_end();
    rd(3'd0, v); check("R10 enable cleared", v, 32'h2);
    rd(3'd3, v); check("R10 done flag", v, 32'h0000_0001);

    // R11 event beats same-cycle clear
    do_reset();
    wr(3'd1, 32'h0000_0002);
    ev(3'd0, 3'd0, 32'h0, 1'b1, 1'b0);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h2;
    ev_valid = 1'b1; ev_kind = 3'd0; ev_chan = 3'd0; ev_sof_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; ev_valid = 1'b0;
    rd(3'd3, v); check("R11 event wins", v, 32'h0000_0002);
    wr(3'd3, 32'h2);
    rd(3'd3, v); check("R11 clear alone", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule